// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Command Chip-Select

This block is a two-wire serial slave (SMBus/I2C-style) that gives a host controller read and write access to a small bank of 8-bit control registers, for example per-output clock enable bits. It samples the serial clock and data lines with the system clock and finds start, stop and bit boundaries from the synchronized samples. The data line is released high and only pulled low through an open-drain enable output.

Each write access begins with a command byte. Bit 7 of that byte selects indexed single-byte access (1) or sequential block access from register 0 (0). Bits 6:5 carry a chip-select code that must match a strap input, so several devices can sit at one bus address. Bits 4:0 carry the register index for single-byte access. The bus address is picked by a second strap. A read is a write of address and command, then a repeated start and the read address. The registers load their reset values and can be rewritten at any time during operation.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave acknowledges the 8-bit write address 0xD2 when `addr_sel_i` is 0 and 0xDC when it is 1 (read address = write address + 1). Any other address byte gets no acknowledge, and the slave stays silent until the next start.
- R2: Command bits 6:5 must be 2'b01 when `cs_strap_i` is 0 and 2'b10 when it is 1. On a mismatch the command byte is not acknowledged, later bytes up to the next start are not acknowledged, and no register changes.
- R3: A command with bit 7 = 1 writes the following data byte to the register indexed by command bits 4:0 and acknowledges it. A second data byte in the same access is not acknowledged and is discarded.
- R4: A single-byte read (write address, command with bit 7 = 1, repeated start, read address) returns the indexed register, most significant bit first.
- R5: A command with bit 7 = 0 stores the following data bytes into registers 0, 1, 2, … in order, whatever command bits 4:0 hold. A stop after any complete byte keeps the bytes already stored.
- R6: A block read returns registers 0, 1, 2, … while the host acknowledges each byte. A host no-acknowledge ends the read and releases the data line.
- R7: Indices 8 to 31 are unimplemented: reads there return 0x00, and writes there are acknowledged but change nothing.
- R8: On reset every register holds 0xFF. A register changes only through an accepted data byte.
- R9: A read address that does not follow an accepted command within the same transfer (no stop between them) is not acknowledged. A write address also clears any earlier command.
- R10: The slave changes `sda_oe_o` only while the synchronized clock line is low, and it never drives the line while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (resolved bus) |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| addr_sel_i | input | 1 | Bus address strap: 0 → 0xD2, 1 → 0xDC |
| cs_strap_i | input | 1 | Chip-select strap compared with command bits 6:5 |
| regs_o | output | NREG*8 | Register bank contents, register k in bits 8k+7:8k |

## Verification
The bound checker watches on every cycle that the data driver only toggles with the synchronized clock low and is off whenever the protocol engine is idle. It also checks that the register bank moves only in the cycle after an accepted write, that writes to unimplemented indices leave the bank untouched, and that write strobes only issue in the acknowledge phase. Address decoding under both strap settings, the chip-select comparison, index decoding, block sequencing, repeated-start reads, discarded extra bytes and the refusal of reads without a command are protocol orderings. Only the bench's bus transactions show those, by comparing acknowledge bits, returned bytes and the register outputs against a model of the bank.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_o;
      sda_q  <= sda_o;
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int                  NREG    = 8,
  parameter int                  IDX_W   = 6,
  parameter logic [NREG*8-1:0]   RST_VAL = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [7:0]         rd_data_o,
  output logic [NREG*8-1:0]  regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL[g*8 +: 8];
      else if (wr_en_i && (wr_idx_i == IDX_W'(g))) q <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = q;
  end

  // unmatched indices fall through to zero
  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs_o[i*8 +: 8];
    end
  end
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_slave_pkg::*;
#(
  parameter logic [7:0] ADDR_LO = 8'hD2,
  parameter logic [7:0] ADDR_HI = 8'hDC,
  parameter int         OFFS_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_sel_i,
  input  logic              cs_strap_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [OFFS_W:0]   wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic [OFFS_W:0]   rd_idx_o,
  output smb_state_e        state_o
);
  smb_state_e        state_q, after_q;
  logic [2:0]        bitcnt_q;
  logic              got8_q;
  logic [7:0]        shreg_q;
  logic              oe_q;
  logic [OFFS_W:0]   ptr_q;
  logic              cmd_ok_q, byte_mode_q, byte_done_q, host_ack_q;
  logic              wr_en_q;
  logic [OFFS_W:0]   wr_idx_q;
  logic [7:0]        wr_data_q;

  logic addr_hit, cs_hit;
  assign addr_hit = shreg_q[7:1] == (addr_sel_i ? ADDR_HI[7:1] : ADDR_LO[7:1]);
  assign cs_hit   = shreg_q[6:5] == (cs_strap_i ? 2'b10 : 2'b01);

  // saturating index step
  function automatic logic [OFFS_W:0] bump(input logic [OFFS_W:0] p);
    return (&p) ? p : p + {{OFFS_W{1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      after_q     <= ST_IDLE;
      bitcnt_q    <= '0;
      got8_q      <= 1'b0;
      shreg_q     <= '0;
      oe_q        <= 1'b0;
      ptr_q       <= '0;
      cmd_ok_q    <= 1'b0;
      byte_mode_q <= 1'b0;
      byte_done_q <= 1'b0;
      host_ack_q  <= 1'b0;
      wr_en_q     <= 1'b0;
      wr_idx_q    <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        bitcnt_q <= '0;
        got8_q   <= 1'b0;
        oe_q     <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        cmd_ok_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise_i) begin
              shreg_q  <= {shreg_q[6:0], sda_s_i};
              bitcnt_q <= bitcnt_q + 3'd1;
              if (bitcnt_q == 3'd7) got8_q <= 1'b1;
            end else if (scl_fall_i && got8_q) begin
              got8_q  <= 1'b0;
              state_q <= ST_IDLE;  // no acknowledge unless accepted below
              case (state_q)
                ST_ADDR: begin
                  if (addr_hit) begin
                    if (!shreg_q[0]) begin
                      oe_q     <= 1'b1;
                      state_q  <= ST_ACK;
                      after_q  <= ST_CMD;
                      cmd_ok_q <= 1'b0;
                    end else if (cmd_ok_q) begin
                      oe_q    <= 1'b1;
                      state_q <= ST_ACK;
                      after_q <= ST_RDATA;
                    end
                  end
                end
                ST_CMD: begin
                  if (cs_hit) begin
                    oe_q        <= 1'b1;
                    state_q     <= ST_ACK;
                    after_q     <= ST_WDATA;
                    cmd_ok_q    <= 1'b1;
                    byte_mode_q <= shreg_q[7];
                    byte_done_q <= 1'b0;
                    ptr_q       <= shreg_q[7] ? {1'b0, shreg_q[OFFS_W-1:0]} : '0;
                  end
                end
                ST_WDATA: begin
                  if (!(byte_mode_q && byte_done_q)) begin
                    oe_q        <= 1'b1;
                    state_q     <= ST_ACK;
                    after_q     <= ST_WDATA;
                    wr_en_q     <= 1'b1;
                    wr_idx_q    <= ptr_q;
                    wr_data_q   <= shreg_q;
                    ptr_q       <= bump(ptr_q);
                    byte_done_q <= 1'b1;
                  end
                end
                default: ;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              state_q  <= after_q;
              bitcnt_q <= '0;
              got8_q   <= 1'b0;
              if (after_q == ST_RDATA) begin
                shreg_q <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
                ptr_q   <= bump(ptr_q);
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              bitcnt_q <= bitcnt_q + 3'd1;
              if (bitcnt_q == 3'd7) got8_q <= 1'b1;
            end else if (scl_fall_i) begin
              if (got8_q) begin
                got8_q  <= 1'b0;
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                oe_q    <= ~shreg_q[6];
                shreg_q <= {shreg_q[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              host_ack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (host_ack_q) begin
                state_q  <= ST_RDATA;
                bitcnt_q <= '0;
                shreg_q  <= rd_data_i;
                oe_q     <= ~rd_data_i[7];
                ptr_q    <= bump(ptr_q);
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign rd_idx_o  = ptr_q;
  assign state_o   = state_q;
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_slave_pkg::*;
#(
  parameter int                NREG        = 8,
  parameter int                OFFS_W      = 5,
  parameter int                SYNC_STAGES = 2,
  parameter logic [7:0]        ADDR_LO     = 8'hD2,
  parameter logic [7:0]        ADDR_HI     = 8'hDC,
  parameter logic [NREG*8-1:0] RST_VAL     = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               addr_sel_i,
  input  logic               cs_strap_i,
  output logic [NREG*8-1:0]  regs_o
);
  localparam int PTR_W = OFFS_W + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;
  smb_state_e       state;

  smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  smb_xfer_fsm #(
    .ADDR_LO (ADDR_LO),
    .ADDR_HI (ADDR_HI),
    .OFFS_W  (OFFS_W)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .addr_sel_i (addr_sel_i),
    .cs_strap_i (cs_strap_i),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx),
    .state_o    (state)
  );

  smb_reg_bank #(
    .NREG    (NREG),
    .IDX_W   (PTR_W),
    .RST_VAL (RST_VAL)
  ) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk
  import smb_slave_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int PTR_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_s_i,
  input logic               sda_oe_i,
  input logic               wr_en_i,
  input logic [PTR_W-1:0]   wr_idx_i,
  input smb_state_e         state_i,
  input logic [NREG*8-1:0]  regs_i
);
  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !scl_s_i);

  p_oe_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_i);

  p_regs_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(regs_i));

  p_oor_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_idx_i >= PTR_W'(NREG))) |=> $stable(regs_i));

  p_wr_in_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (state_i == ST_ACK));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NREG(NREG), .PTR_W(PTR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s_i  (scl_s),
  .sda_oe_i (sda_oe_o),
  .wr_en_i  (wr_en),
  .wr_idx_i (wr_idx),
  .state_i  (state),
  .regs_i   (regs_o)
);

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
  localparam int NREG = 8;
  localparam int HP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic asel = 1'b0;
  logic cs = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] regs;

  int n_cmp = 0;
  int n_err = 0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;
  assign sda_line = host_sda & ~sda_oe;

  smb_reg_slave i_smb_reg_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .addr_sel_i (asel),
    .cs_strap_i (cs),
    .regs_o     (regs)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, 32'(regs[i*8 +: 8]), 32'(model[i]));
  endtask

  function automatic logic [7:0] waddr();
    return asel ? 8'hDC : 8'hD2;
  endfunction

  function automatic logic [1:0] cs_code();
    return cs ? 2'b10 : 2'b01;
  endfunction

  task automatic bus_start();
    host_sda = 1'b1; tick(HP);
    scl = 1'b1;      tick(HP);
    host_sda = 1'b0; tick(HP);
    scl = 1'b0;      tick(HP);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(HP);
    scl = 1'b1;      tick(HP);
    host_sda = 1'b1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; tick(HP);
      scl = 1'b1;      tick(HP);
      scl = 1'b0;      tick(2);
    end
    host_sda = 1'b1; tick(HP);
    scl = 1'b1;      tick(HP/2);
    ack = (sda_line == 1'b0);
    tick(HP/2);
    scl = 1'b0;      tick(2);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP);
      scl = 1'b1; tick(HP/2);
      b[i] = sda_line;
      tick(HP/2);
      scl = 1'b0; tick(2);
    end
    host_sda = give_ack ? 1'b0 : 1'b1; tick(HP);
    scl = 1'b1; tick(HP);
    scl = 1'b0; tick(2);
    host_sda = 1'b1;
  endtask

  task automatic byte_write(input logic [4:0] off, input logic [7:0] d);
    logic a;
    bus_start();
    send_byte(waddr(), a);                   chk("R1 write address ack", 32'(a), 1);
    send_byte({1'b1, cs_code(), off}, a);    chk("R2 command ack", 32'(a), 1);
    send_byte(d, a);                         chk("R3 data ack", 32'(a), 1);
    bus_stop();
    if (off < 5'(NREG)) model[off] = d;
  endtask

  task automatic byte_read(input logic [4:0] off, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(waddr(), a);                   chk("R4 address ack", 32'(a), 1);
    send_byte({1'b1, cs_code(), off}, a);    chk("R4 command ack", 32'(a), 1);
    bus_start();
    send_byte(waddr() | 8'h01, a);           chk("R4 read address ack", 32'(a), 1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R8: reset contents, R10: released
    chk_regs("R8 reset value");
    chk("R10 idle release", 32'(sda_oe), 0);

    // R3/R4/R7: sweep every index
    for (int off = 0; off < 32; off++) begin
      logic [7:0] v;
      v = 8'(off * 29 + 5);
      byte_write(5'(off), v);
      chk_regs(off < NREG ? "R3 byte write" : "R7 ignored write");
      byte_read(5'(off), d);
      chk(off < NREG ? "R4 byte read" : "R7 zero read", 32'(d),
          32'(off < NREG ? model[off] : 8'h00));
      chk("R10 released after stop", 32'(sda_oe), 0);
    end

    // R3: second byte in byte mode refused
    bus_start();
    send_byte(waddr(), a);
    send_byte({1'b1, cs_code(), 5'd2}, a);
    send_byte(8'hA5, a);       chk("R3 first data ack", 32'(a), 1);
    send_byte(8'h3C, a);       chk("R3 extra byte nack", 32'(a), 0);
    bus_stop();
    model[2] = 8'hA5;
    chk_regs("R3 extra byte discarded");

    // R1: foreign addresses
    foreach (model[k]) begin end
    begin
      logic [7:0] bad [3] = '{8'hDC, 8'hD4, 8'h52};
      for (int k = 0; k < 3; k++) begin
        bus_start();
        send_byte(bad[k], a);  chk("R1 foreign address nack", 32'(a), 0);
        bus_stop();
      end
    end

    // R2: wrong chip-select codes
    for (int c = 0; c < 4; c++) begin
      if (2'(c) != cs_code()) begin
        bus_start();
        send_byte(waddr(), a);
        send_byte({1'b1, 2'(c), 5'd1}, a);  chk("R2 wrong code nack", 32'(a), 0);
        send_byte(8'h00, a);                chk("R2 data after wrong code nack", 32'(a), 0);
        bus_stop();
        chk_regs("R2 no change");
      end
    end

    // R5: block write, offset bits ignored, early stop
    bus_start();
    send_byte(waddr(), a);
    send_byte({1'b0, cs_code(), 5'd5}, a);  chk("R5 block command ack", 32'(a), 1);
    for (int k = 0; k < 5; k++) begin
      send_byte(8'(k * 17 + 8'h40), a);     chk("R5 block data ack", 32'(a), 1);
      model[k] = 8'(k * 17 + 8'h40);
    end
    bus_stop();
    chk_regs("R5 partial block write");

    // R7: block write past the end
    bus_start();
    send_byte(waddr(), a);
    send_byte({1'b0, cs_code(), 5'd0}, a);
    for (int k = 0; k < 10; k++) begin
      send_byte(8'(8'h90 + k), a);          chk(k < NREG ? "R5 block data ack" : "R7 past-end ack", 32'(a), 1);
      if (k < NREG) model[k] = 8'(8'h90 + k);
    end
    bus_stop();
    chk_regs("R7 past-end write");

    // R6/R7: block read across the end
    bus_start();
    send_byte(waddr(), a);
    send_byte({1'b0, cs_code(), 5'd0}, a);
    bus_start();
    send_byte(waddr() | 8'h01, a);          chk("R6 read address ack", 32'(a), 1);
    for (int k = 0; k < 10; k++) begin
      recv_byte(k != 9, d);
      chk(k < NREG ? "R6 block read" : "R7 block read zero", 32'(d),
          32'(k < NREG ? model[k] : 8'h00));
    end
    chk("R6 released after nack", 32'(sda_oe), 0);
    bus_stop();

    // R6: short block read ended early
    bus_start();
    send_byte(waddr(), a);
    send_byte({1'b0, cs_code(), 5'd0}, a);
    bus_start();
    send_byte(waddr() | 8'h01, a);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, d);
      chk("R6 short block read", 32'(d), 32'(model[k]));
    end
    chk("R6 line free after nack", 32'(sda_line), 1);
    bus_stop();

    // R9: read without command
    bus_start();
    send_byte(waddr() | 8'h01, a);          chk("R9 bare read nack", 32'(a), 0);
    bus_stop();
    bus_start();
    send_byte(waddr(), a);
    bus_start();
    send_byte(waddr() | 8'h01, a);          chk("R9 read after address only nack", 32'(a), 0);
    bus_stop();

    // R1/R2/R4: other strap settings
    for (int cfg = 1; cfg < 4; cfg++) begin
      logic [7:0] v;
      logic [4:0] o;
      asel = cfg[0];
      cs   = cfg[1];
      tick(HP);
      bus_start();
      send_byte(asel ? 8'hD2 : 8'hDC, a);   chk("R1 other strap address nack", 32'(a), 0);
      bus_stop();
      bus_start();
      send_byte(waddr(), a);
      send_byte({1'b1, ~cs_code(), 5'd3}, a); chk("R2 other code nack", 32'(a), 0);
      bus_stop();
      o = 5'(3 + cfg);
      v = 8'(8'h11 * cfg + 8'h06);
      byte_write(o, v);
      chk_regs("R3 strap config write");
      byte_read(o, d);
      chk("R4 strap config read", 32'(d), 32'(v));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule